// File: doc/BRIEF.md
# Packet network interface register controller

This block is the host-side register set of a small packet network adapter that moves all data by programmed I/O. The host reaches it through a 16-bit word register port with a byte offset, a one-cycle read latency and a level interrupt request. There is one single-packet transmit buffer and one single-packet receive buffer. The host fills the transmit buffer through one repeated data register and empties the receive buffer through another.

The line side is an abstract word stream. On receive it carries valid, start, end, a CRC verdict and a 16-bit data word. On transmit it carries valid, start, end and data, plus a collision abort input from the link model. The first word of every packet is its destination address. A control/status word holds the enables, the flags, a saturating count of lost packets, promiscuous listening and an internal loop path. A node address input, a received-bit count and an interval timer driven by an external tick complete the set.

Top module: `pkt_nic_regs`

## Requirements
- R1: After reset the status word reads 16'h0080 (only transmitter done set), the bit count reads 0, `irq` is low and no line word is sent.
- R2: Every register read returns its data on `bus_rdata` in the cycle after `bus_re`. Offset 2 reads the `node_addr` input (subnet in bits 15..8, host in bits 7..0). Offsets 8, 12 and 14 read 0.
- R3: In the status word (offset 0), bit0 timer irq enable, bit1 loopback, bit2 spy, bit4 receive irq enable and bit5 transmit irq enable read back as written. The strobe bits 3 (receiver clear), 8 (transmitter clear) and 13 (interface reset) always read 0.
- R4: An accepted packet is stored word by word and sets receive done (bit15) at its end. Successive reads of offset 4 return the words in arrival order. Offset 6 reads the stored word count times 16 in bits 11..0, with bits 15..12 zero.
- R5: When spy is clear, only packets whose first word equals `node_addr` or 0 are accepted. When spy is set, every packet is accepted.
- R6: A packet that would be accepted while receive done is set is dropped and increments the lost count (bits 12..9). The count saturates at 15. Receiver clear zeroes receive done, the CRC error flag, the lost count and the bit count, and rewinds the read pointer.
- R7: A packet that ends with `line_rx_crc_ok` low sets the CRC error flag (bit14).
- R8: Each write to offset 2 appends one word to the transmit buffer. Transmitter clear rewinds it. A write to offset 10 clears transmitter done (bit7) and sends the buffered words in order, one per cycle, with start on the first word and end on the last. Transmitter done sets again after the last word.
- R9: A `line_tx_abort` during sending stops the packet and sets both transmitter done and the aborted flag (bit6).
- R10: When loopback is set, sent words go into the receive path (CRC taken as good) and none appear on the line outputs.
- R11: `irq` is high one cycle after (receive done and receive enable) or (transmitter done and transmit enable) or (timer expired and timer enable) holds, and low one cycle after none holds.
- R12: A write to offset 16 loads the interval timer and clears its expiry. Each `timer_tick` decrements a nonzero count, and reaching zero marks it expired.
- R13: A status write with bit13 set clears, one cycle later, all enables, flags, counters, the timer and the buffer pointers, and leaves transmitter done set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid the cycle after `bus_re` |
| irq | output | 1 | Interrupt request |
| node_addr | input | 16 | This node's address |
| line_tx_valid | output | 1 | Outgoing word valid |
| line_tx_sop | output | 1 | First word of the outgoing packet |
| line_tx_eop | output | 1 | Last word of the outgoing packet |
| line_tx_data | output | 16 | Outgoing word |
| line_tx_abort | input | 1 | Collision abort from the link |
| line_rx_valid | input | 1 | Incoming word valid |
| line_rx_sop | input | 1 | First word of an incoming packet |
| line_rx_eop | input | 1 | Last word of an incoming packet |
| line_rx_crc_ok | input | 1 | CRC verdict, sampled with the last word |
| line_rx_data | input | 16 | Incoming word |
| timer_tick | input | 1 | Interval timer decrement pulse |

## Verification
Register reads return data one cycle after the strobe. Receive flags, the lost count and the bit count change at the edge that takes the final word of a packet. `irq` follows its sources one further edge later. After a transmit start written at edge E, word i leaves after edge E+1+i and transmitter done rises after edge E+1+N. The bench drives inputs and samples outputs on falling edges. It waits these exact cycle counts before an `irq` check and allows a generous settle time before checking a finished transmission. A falling-edge monitor records every line word, so counts and order are checked without guessing the arrival cycle.

// File: rtl/pkt_nic_pkg.sv
package pkt_nic_pkg;

  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] OFF_CSR   = 5'd0;
  localparam logic [ADDR_W-1:0] OFF_NODE  = 5'd2;
  localparam logic [ADDR_W-1:0] OFF_RBUF  = 5'd4;
  localparam logic [ADDR_W-1:0] OFF_RBITS = 5'd6;
  localparam logic [ADDR_W-1:0] OFF_XMIT  = 5'd10;
  localparam logic [ADDR_W-1:0] OFF_TIMER = 5'd16;

  localparam int CB_TIE  = 0;
  localparam int CB_LPBK = 1;
  localparam int CB_SPY  = 2;
  localparam int CB_RCLR = 3;
  localparam int CB_REN  = 4;
  localparam int CB_TEN  = 5;
  localparam int CB_TAB  = 6;
  localparam int CB_TDN  = 7;
  localparam int CB_TCLR = 8;
  localparam int CB_LOST = 9;
  localparam int CB_IRST = 13;
  localparam int CB_CRC  = 14;
  localparam int CB_RDN  = 15;

  localparam int LOST_W = 4;

  typedef struct packed {
    logic ten;
    logic ren;
    logic spy;
    logic lpbk;
    logic tie;
  } ctl_t;

endpackage

// File: rtl/nic_word_buf.sv
module nic_word_buf #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_en,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  // simple dual-port, registered read: maps onto one block RAM
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/nic_tx_engine.sv
module nic_tx_engine #(
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          start,
  input  logic          abort,
  input  logic [CW-1:0] len,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          out_valid,
  output logic          out_sop,
  output logic          out_eop,
  output logic          done,
  output logic          aborted
);

  logic          busy;
  logic [CW-1:0] idx;
  logic          last;

  assign rd_en   = busy && !abort;
  assign rd_addr = idx[AW-1:0];
  assign last    = (idx + CW'(1)) >= len;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      busy      <= 1'b0;
      idx       <= '0;
      out_valid <= 1'b0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
      done      <= 1'b1;
      aborted   <= 1'b0;
    end else begin
      // buffer data lands one cycle after the address, flags follow it
      out_valid <= rd_en;
      out_sop   <= rd_en && (idx == '0);
      out_eop   <= rd_en && last;
      if (rd_en) begin
        idx <= idx + CW'(1);
        if (last) busy <= 1'b0;
      end
      if (out_valid && out_eop) done <= 1'b1;
      if (abort && (busy || out_valid)) begin
        busy      <= 1'b0;
        out_valid <= 1'b0;
        out_sop   <= 1'b0;
        out_eop   <= 1'b0;
        done      <= 1'b1;
        aborted   <= 1'b1;
      end
      if (start && !busy && !out_valid) begin
        aborted <= 1'b0;
        if (len == '0) begin
          done <= 1'b1;
        end else begin
          busy <= 1'b1;
          idx  <= '0;
          done <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/nic_rx_engine.sv
module nic_rx_engine #(
  parameter int DEPTH    = 256,
  parameter int BITCNT_W = 12,
  parameter int LOST_W   = 4,
  localparam int AW      = $clog2(DEPTH),
  localparam int CW      = AW + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr,
  input  logic                rclr,
  input  logic                spy,
  input  logic [15:0]         node_addr,
  input  logic                in_valid,
  input  logic                in_sop,
  input  logic                in_eop,
  input  logic                in_crc_ok,
  input  logic [15:0]         in_data,
  output logic                wr_en,
  output logic [AW-1:0]       wr_addr,
  output logic [15:0]         wr_data,
  output logic                rx_done,
  output logic                crc_err,
  output logic [LOST_W-1:0]   lost,
  output logic [BITCNT_W-1:0] bit_count
);

  logic          acc;
  logic [CW-1:0] wptr;
  logic          match;
  logic          take;
  logic          room;
  logic [CW-1:0] cnt_next;

  assign match    = spy || (in_data == node_addr) || (in_data == '0);
  assign take     = in_valid && (in_sop ? (match && !rx_done) : acc);
  assign room     = wptr < CW'(DEPTH);
  assign cnt_next = in_sop ? CW'(1) : (room ? wptr + CW'(1) : wptr);
  assign wr_en    = take && (in_sop || room);
  assign wr_addr  = in_sop ? '0 : wptr[AW-1:0];
  assign wr_data  = in_data;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      acc       <= 1'b0;
      wptr      <= '0;
      rx_done   <= 1'b0;
      crc_err   <= 1'b0;
      lost      <= '0;
      bit_count <= '0;
    end else begin
      if (take) begin
        wptr <= cnt_next;
        acc  <= !in_eop;
        if (in_eop) begin
          rx_done   <= 1'b1;
          crc_err   <= !in_crc_ok;
          bit_count <= BITCNT_W'({cnt_next, 4'b0000});
        end
      end else if (in_valid && in_sop) begin
        acc <= 1'b0;
      end
      if (in_valid && in_sop && match && rx_done && (lost != '1))
        lost <= lost + LOST_W'(1);
      if (rclr) begin
        acc       <= 1'b0;
        rx_done   <= 1'b0;
        crc_err   <= 1'b0;
        lost      <= '0;
        bit_count <= '0;
      end
    end
  end

endmodule

// File: rtl/nic_interval_timer.sv
module nic_interval_timer #(
  parameter int TIMER_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               load,
  input  logic [TIMER_W-1:0] load_val,
  input  logic               tick,
  output logic               expired
);

  logic [TIMER_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (load) begin
      cnt     <= load_val;
      expired <= 1'b0;
    end else if (tick && (cnt != '0)) begin
      cnt <= cnt - TIMER_W'(1);
      if (cnt == TIMER_W'(1)) expired <= 1'b1;
    end
  end

endmodule

// File: rtl/pkt_nic_regs.sv
module pkt_nic_regs
  import pkt_nic_pkg::*;
#(
  parameter int BUF_DEPTH = 256,
  parameter int TIMER_W   = 16,
  parameter int BITCNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic              bus_re,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic              irq,
  input  logic [15:0]       node_addr,
  output logic              line_tx_valid,
  output logic              line_tx_sop,
  output logic              line_tx_eop,
  output logic [15:0]       line_tx_data,
  input  logic              line_tx_abort,
  input  logic              line_rx_valid,
  input  logic              line_rx_sop,
  input  logic              line_rx_eop,
  input  logic              line_rx_crc_ok,
  input  logic [15:0]       line_rx_data,
  input  logic              timer_tick
);

  localparam int AW = $clog2(BUF_DEPTH);
  localparam int CW = AW + 1;

  // ---------------- decode ----------------
  logic wr_csr, wr_tbuf, wr_xmit, wr_timer, rd_rbuf;
  logic rclr_p, tclr_p, ireset_q;

  assign wr_csr   = bus_we && (bus_addr == OFF_CSR);
  assign wr_tbuf  = bus_we && (bus_addr == OFF_NODE);
  assign wr_xmit  = bus_we && (bus_addr == OFF_XMIT);
  assign wr_timer = bus_we && (bus_addr == OFF_TIMER);
  assign rd_rbuf  = bus_re && (bus_addr == OFF_RBUF);
  assign rclr_p   = wr_csr && bus_wdata[CB_RCLR];
  assign tclr_p   = wr_csr && bus_wdata[CB_TCLR];

  // ---------------- control bits ----------------
  ctl_t ctl;

  always_ff @(posedge clk) begin
    if (rst) ireset_q <= 1'b0;
    else     ireset_q <= wr_csr && bus_wdata[CB_IRST];
  end

  always_ff @(posedge clk) begin
    if (rst || ireset_q) begin
      ctl <= '0;
    end else if (wr_csr) begin
      ctl.tie  <= bus_wdata[CB_TIE];
      ctl.lpbk <= bus_wdata[CB_LPBK];
      ctl.spy  <= bus_wdata[CB_SPY];
      ctl.ren  <= bus_wdata[CB_REN];
      ctl.ten  <= bus_wdata[CB_TEN];
    end
  end

  // ---------------- transmit side ----------------
  logic [CW-1:0] tx_cnt;
  logic          tx_room;
  logic          tx_rd_en;
  logic [AW-1:0] tx_rd_addr;
  logic [15:0]   tx_word;
  logic          tx_v, tx_s, tx_e;
  logic          tx_done, tx_aborted;

  assign tx_room = tx_cnt < CW'(BUF_DEPTH);

  always_ff @(posedge clk) begin
    if (rst || ireset_q || tclr_p) tx_cnt <= '0;
    else if (wr_tbuf && tx_room)   tx_cnt <= tx_cnt + CW'(1);
  end

  nic_word_buf #(.DEPTH(BUF_DEPTH), .WIDTH(16)) u_tx_buf (
    .clk     (clk),
    .wr_en   (wr_tbuf && tx_room),
    .wr_addr (tx_cnt[AW-1:0]),
    .wr_data (bus_wdata),
    .rd_en   (tx_rd_en),
    .rd_addr (tx_rd_addr),
    .rd_data (tx_word)
  );

  nic_tx_engine #(.DEPTH(BUF_DEPTH)) u_tx_eng (
    .clk       (clk),
    .rst       (rst),
    .clr       (ireset_q),
    .start     (wr_xmit),
    .abort     (line_tx_abort && !ctl.lpbk),
    .len       (tx_cnt),
    .rd_en     (tx_rd_en),
    .rd_addr   (tx_rd_addr),
    .out_valid (tx_v),
    .out_sop   (tx_s),
    .out_eop   (tx_e),
    .done      (tx_done),
    .aborted   (tx_aborted)
  );

  assign line_tx_valid = tx_v && !ctl.lpbk;
  assign line_tx_sop   = tx_s && !ctl.lpbk;
  assign line_tx_eop   = tx_e && !ctl.lpbk;
  assign line_tx_data  = tx_word;

  // ---------------- receive side ----------------
  logic                rx_v, rx_s, rx_e, rx_ok;
  logic [15:0]         rx_d;
  logic                rx_we;
  logic [AW-1:0]       rx_wa;
  logic [15:0]         rx_wd;
  logic                rx_done, rx_crc_err;
  logic [LOST_W-1:0]   rx_lost;
  logic [BITCNT_W-1:0] rx_bits;
  logic [AW-1:0]       rx_rd_ptr;
  logic [15:0]         rx_word;

  assign rx_v  = ctl.lpbk ? tx_v    : line_rx_valid;
  assign rx_s  = ctl.lpbk ? tx_s    : line_rx_sop;
  assign rx_e  = ctl.lpbk ? tx_e    : line_rx_eop;
  assign rx_ok = ctl.lpbk ? 1'b1    : line_rx_crc_ok;
  assign rx_d  = ctl.lpbk ? tx_word : line_rx_data;

  nic_rx_engine #(.DEPTH(BUF_DEPTH), .BITCNT_W(BITCNT_W), .LOST_W(LOST_W)) u_rx_eng (
    .clk       (clk),
    .rst       (rst),
    .clr       (ireset_q),
    .rclr      (rclr_p),
    .spy       (ctl.spy),
    .node_addr (node_addr),
    .in_valid  (rx_v),
    .in_sop    (rx_s),
    .in_eop    (rx_e),
    .in_crc_ok (rx_ok),
    .in_data   (rx_d),
    .wr_en     (rx_we),
    .wr_addr   (rx_wa),
    .wr_data   (rx_wd),
    .rx_done   (rx_done),
    .crc_err   (rx_crc_err),
    .lost      (rx_lost),
    .bit_count (rx_bits)
  );

  always_ff @(posedge clk) begin
    if (rst || ireset_q || rclr_p) rx_rd_ptr <= '0;
    else if (rd_rbuf)              rx_rd_ptr <= rx_rd_ptr + AW'(1);
  end

  nic_word_buf #(.DEPTH(BUF_DEPTH), .WIDTH(16)) u_rx_buf (
    .clk     (clk),
    .wr_en   (rx_we),
    .wr_addr (rx_wa),
    .wr_data (rx_wd),
    .rd_en   (rd_rbuf),
    .rd_addr (rx_rd_ptr),
    .rd_data (rx_word)
  );

  // ---------------- timer ----------------
  logic tmr_exp;

  nic_interval_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .clr      (ireset_q),
    .load     (wr_timer),
    .load_val (TIMER_W'(bus_wdata)),
    .tick     (timer_tick),
    .expired  (tmr_exp)
  );

  // ---------------- read-back and interrupt ----------------
  logic [15:0] csr_word;
  logic [15:0] rdata_q;
  logic        sel_rbuf_q;

  always_comb begin
    csr_word = '0;
    csr_word[CB_TIE]  = ctl.tie;
    csr_word[CB_LPBK] = ctl.lpbk;
    csr_word[CB_SPY]  = ctl.spy;
    csr_word[CB_REN]  = ctl.ren;
    csr_word[CB_TEN]  = ctl.ten;
    csr_word[CB_TAB]  = tx_aborted;
    csr_word[CB_TDN]  = tx_done;
    csr_word[CB_LOST +: LOST_W] = rx_lost;
    csr_word[CB_CRC]  = rx_crc_err;
    csr_word[CB_RDN]  = rx_done;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q    <= '0;
      sel_rbuf_q <= 1'b0;
      irq        <= 1'b0;
    end else begin
      sel_rbuf_q <= rd_rbuf;
      if (bus_re) begin
        case (bus_addr)
          OFF_CSR:   rdata_q <= csr_word;
          OFF_NODE:  rdata_q <= node_addr;
          OFF_RBITS: rdata_q <= 16'(rx_bits);
          default:   rdata_q <= '0;
        endcase
      end
      irq <= (rx_done && ctl.ren) || (tx_done && ctl.ten) || (tmr_exp && ctl.tie);
    end
  end

  assign bus_rdata = sel_rbuf_q ? rx_word : rdata_q;

endmodule

// File: rtl/pkt_nic_regs_chk.sv
module pkt_nic_regs_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq,
  input logic       line_tx_valid,
  input logic       line_tx_sop,
  input logic       line_tx_eop,
  input logic       lpbk,
  input logic       ren,
  input logic       ten,
  input logic       tie,
  input logic       tdn,
  input logic       tab,
  input logic [3:0] lost,
  input logic       rclr_p,
  input logic       ireset_q
);

  // R6
  lost_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (lost == 4'hF && !rclr_p && !ireset_q) |=> (lost == 4'hF));

  // R11
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!ren && !ten && !tie) |=> !irq);

  // R9
  abort_done_chk: assert property (@(posedge clk) disable iff (rst)
    tab |-> tdn);

  // R8
  sending_chk: assert property (@(posedge clk) disable iff (rst)
    line_tx_valid |-> !tdn);

  // R8
  frame_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (line_tx_sop || line_tx_eop) |-> line_tx_valid);

  // R10
  loop_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    lpbk |-> !line_tx_valid);

  // R13
  iface_reset_chk: assert property (@(posedge clk) disable iff (rst)
    ireset_q |=> (!ren && !ten && !tie && !lpbk && lost == 4'h0 && tdn && !tab));

endmodule

bind pkt_nic_regs pkt_nic_regs_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .irq           (irq),
  .line_tx_valid (line_tx_valid),
  .line_tx_sop   (line_tx_sop),
  .line_tx_eop   (line_tx_eop),
  .lpbk          (ctl.lpbk),
  .ren           (ctl.ren),
  .ten           (ctl.ten),
  .tie           (ctl.tie),
  .tdn           (tx_done),
  .tab           (tx_aborted),
  .lost          (rx_lost),
  .rclr_p        (rclr_p),
  .ireset_q      (ireset_q)
);

// File: tb/pkt_nic_regs_bench.sv
module pkt_nic_regs_bench;

  localparam logic [15:0] NODE = 16'h0A05;
  localparam logic [4:0] A_CSR = 5'd0, A_NODE = 5'd2, A_RBUF = 5'd4, A_BITS = 5'd6;
  localparam logic [4:0] A_XMIT = 5'd10, A_TIMER = 5'd16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_we = 0, bus_re = 0;
  logic [4:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq;
  logic line_tx_valid, line_tx_sop, line_tx_eop;
  logic [15:0] line_tx_data;
  logic line_tx_abort = 0;
  logic line_rx_valid = 0, line_rx_sop = 0, line_rx_eop = 0, line_rx_crc_ok = 1;
  logic [15:0] line_rx_data = '0;
  logic timer_tick = 0;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [15:0] pkt [16];
  logic [15:0] cap [64];
  bit          cap_sop [64];
  bit          cap_eop [64];
  int          cap_n = 0;

  always #4 clk = ~clk;

  pkt_nic_regs u_pkt_nic_regs (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .node_addr(NODE),
    .line_tx_valid(line_tx_valid), .line_tx_sop(line_tx_sop), .line_tx_eop(line_tx_eop),
    .line_tx_data(line_tx_data), .line_tx_abort(line_tx_abort),
    .line_rx_valid(line_rx_valid), .line_rx_sop(line_rx_sop), .line_rx_eop(line_rx_eop),
    .line_rx_crc_ok(line_rx_crc_ok), .line_rx_data(line_rx_data), .timer_tick(timer_tick)
  );

  always @(negedge clk) begin
    if (line_tx_valid) begin
      cap[cap_n % 64]     = line_tx_data;
      cap_sop[cap_n % 64] = line_tx_sop;
      cap_eop[cap_n % 64] = line_tx_eop;
      cap_n = cap_n + 1;
    end
  end

  task automatic check(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_re = 1; bus_addr = a;
    @(negedge clk);
    bus_re = 0;
    d = bus_rdata;
  endtask

  task automatic send_pkt(input int n, input logic ok);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      line_rx_valid = 1; line_rx_sop = (i == 0); line_rx_eop = (i == n - 1);
      line_rx_data = pkt[i]; line_rx_crc_ok = ok;
    end
    @(negedge clk);
    line_rx_valid = 0; line_rx_sop = 0; line_rx_eop = 0; line_rx_crc_ok = 1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    rd(A_CSR, v);  check("R1", "status after reset", v, 16'h0080);
    rd(A_BITS, v); check("R1", "bit count after reset", v, 16'h0000);
    check("R1", "irq after reset", {15'd0, irq}, 16'h0000);
    check("R1", "no line word", 16'(cap_n), 16'h0000);
  endtask

  task automatic t_reads();
    logic [15:0] v;
    rd(A_NODE, v); check("R2", "node address", v, NODE);
    rd(5'd8, v);   check("R2", "offset 8", v, 16'h0000);
    rd(5'd12, v);  check("R2", "offset 12", v, 16'h0000);
  endtask

  task automatic t_ctl_bits();
    logic [15:0] v;
    wr(A_CSR, 16'h213F & ~16'h2000 | 16'h0000);
    rd(A_CSR, v); check("R3", "control readback, strobes zero", v, 16'h00B7);
    wr(A_CSR, 16'h0000);
    rd(A_CSR, v); check("R3", "control cleared", v, 16'h0080);
  endtask

  task automatic t_rx_basic();
    logic [15:0] v;
    pkt[0] = NODE; pkt[1] = 16'hA1A1; pkt[2] = 16'h5A5A;
    send_pkt(3, 1);
    rd(A_CSR, v);  check("R4", "receive done", v, 16'h8080);
    rd(A_BITS, v); check("R4", "bit count 3 words", v, 16'h0030);
    for (int i = 0; i < 3; i++) begin
      rd(A_RBUF, v); check("R4", "receive word order", v, pkt[i]);
    end
  endtask

  task automatic t_filter();
    logic [15:0] v;
    wr(A_CSR, 16'h0008);
    pkt[0] = 16'h1234; pkt[1] = 16'h0001;
    send_pkt(2, 1);
    rd(A_CSR, v); check("R5", "foreign packet dropped", v, 16'h0080);
    pkt[0] = 16'h0000; pkt[1] = 16'h0007;
    send_pkt(2, 1);
    rd(A_CSR, v); check("R5", "broadcast accepted", v, 16'h8080);
    wr(A_CSR, 16'h000C);
    pkt[0] = 16'h1234;
    send_pkt(2, 1);
    rd(A_CSR, v); check("R5", "spy accepts foreign", v, 16'h8084);
  endtask

  task automatic t_lost();
    logic [15:0] v;
    pkt[0] = 16'h4444;
    repeat (2) send_pkt(1, 1);
    rd(A_CSR, v); check("R6", "lost count 2", v, 16'h8484);
    repeat (15) send_pkt(1, 1);
    rd(A_CSR, v); check("R6", "lost count saturates", v, 16'h9E84);
    wr(A_CSR, 16'h0008);
    rd(A_CSR, v); check("R6", "receiver clear", v, 16'h0080);
    rd(A_BITS, v); check("R6", "bit count cleared", v, 16'h0000);
  endtask

  task automatic t_crc();
    logic [15:0] v;
    pkt[0] = NODE; pkt[1] = 16'h0101;
    send_pkt(2, 0);
    rd(A_CSR, v); check("R7", "crc error flag", v, 16'hC080);
    wr(A_CSR, 16'h0008);
    rd(A_CSR, v); check("R7", "crc flag cleared", v, 16'h0080);
  endtask

  task automatic t_tx();
    logic [15:0] v;
    int base;
    wr(A_CSR, 16'h0100);
    wr(A_NODE, 16'h1111); wr(A_NODE, 16'h2222); wr(A_NODE, 16'h3333);
    base = cap_n;
    wr(A_XMIT, 16'h0000);
    rd(A_CSR, v); check("R8", "done clear while sending", v & 16'h0080, 16'h0000);
    idle(10);
    rd(A_CSR, v); check("R8", "done after send", v, 16'h0080);
    check("R8", "word count sent", 16'(cap_n - base), 16'd3);
    check("R8", "word 0", cap[base % 64], 16'h1111);
    check("R8", "word 1", cap[(base + 1) % 64], 16'h2222);
    check("R8", "word 2", cap[(base + 2) % 64], 16'h3333);
    check("R8", "start flag", {15'd0, cap_sop[base % 64]}, 16'd1);
    check("R8", "end flag", {15'd0, cap_eop[(base + 2) % 64]}, 16'd1);
  endtask

  task automatic t_abort();
    logic [15:0] v;
    int base;
    wr(A_CSR, 16'h0100);
    for (int i = 0; i < 4; i++) wr(A_NODE, 16'(16'h0C00 + i));
    base = cap_n;
    wr(A_XMIT, 16'h0000);
    @(negedge clk); line_tx_abort = 1;
    @(negedge clk); line_tx_abort = 0;
    idle(6);
    check("R9", "words before abort", 16'(cap_n - base), 16'd1);
    rd(A_CSR, v); check("R9", "aborted and done", v, 16'h00C0);
  endtask

  task automatic t_loop();
    logic [15:0] v;
    int base;
    wr(A_CSR, 16'h010A);
    wr(A_NODE, NODE); wr(A_NODE, 16'hBEEF);
    base = cap_n;
    wr(A_XMIT, 16'h0000);
    idle(8);
    check("R10", "no line words", 16'(cap_n - base), 16'd0);
    rd(A_CSR, v);  check("R10", "looped packet received", v, 16'h8082);
    rd(A_BITS, v); check("R10", "looped bit count", v, 16'h0020);
    rd(A_RBUF, v); check("R10", "looped word 0", v, NODE);
    rd(A_RBUF, v); check("R10", "looped word 1", v, 16'hBEEF);
    wr(A_CSR, 16'h0008);
  endtask

  task automatic t_irq();
    wr(A_CSR, 16'h0020); idle(1);
    check("R11", "irq on tx done", {15'd0, irq}, 16'd1);
    wr(A_CSR, 16'h0000); idle(1);
    check("R11", "irq off", {15'd0, irq}, 16'd0);
    pkt[0] = NODE; send_pkt(1, 1);
    idle(1);
    check("R11", "rx done without enable", {15'd0, irq}, 16'd0);
    wr(A_CSR, 16'h0010); idle(1);
    check("R11", "irq on rx done", {15'd0, irq}, 16'd1);
    wr(A_CSR, 16'h0008); idle(1);
    check("R11", "irq after clear", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_timer();
    wr(A_CSR, 16'h0001);
    wr(A_TIMER, 16'd3);
    repeat (2) begin
      @(negedge clk); timer_tick = 1;
      @(negedge clk); timer_tick = 0;
    end
    idle(1);
    check("R12", "timer not yet expired", {15'd0, irq}, 16'd0);
    @(negedge clk); timer_tick = 1;
    @(negedge clk); timer_tick = 0;
    idle(1);
    check("R12", "timer expiry irq", {15'd0, irq}, 16'd1);
    wr(A_TIMER, 16'd0); idle(1);
    check("R12", "reload clears expiry", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_iface_reset();
    logic [15:0] v;
    int base;
    wr(A_CSR, 16'h0008);
    pkt[0] = NODE;
    repeat (3) send_pkt(1, 1);
    wr(A_NODE, 16'h7777);
    wr(A_CSR, 16'h2036);
    idle(1);
    rd(A_CSR, v); check("R13", "interface reset state", v, 16'h0080);
    wr(A_NODE, 16'h9999);
    base = cap_n;
    wr(A_XMIT, 16'h0000);
    idle(6);
    check("R13", "tx pointer rewound", 16'(cap_n - base), 16'd1);
    check("R13", "first word after reset", cap[base % 64], 16'h9999);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_reads();
    t_ctl_bits();
    t_rx_basic();
    t_filter();
    t_lost();
    t_crc();
    t_tx();
    t_abort();
    t_loop();
    t_irq();
    t_timer();
    t_iface_reset();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=%h expected=%h", 16'h0, 16'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule